// File: doc/BRIEF.md
# Ping-Pong Peripheral-to-Memory DMA Channel

This block is one DMA channel that carries items from a peripheral into memory, alternating between two memory buffers. Software programs two buffer base addresses and an item count, then sets the enable. Each peripheral request moves one item, which leaves the channel as one write beat on a simple valid/ready memory port. The acknowledge back to the peripheral follows once memory has taken the beat.

When the last item of a buffer is written, the channel flips its current-target bit and reloads the remaining-item counter from the programmed count. It then carries on into the other buffer with no software involvement. A consumer can drain the buffer that just filled while the other one fills. Each buffer switch raises a one-cycle completion pulse and sets a sticky flag. Any bus master can clear that flag by writing a one to the clear mask.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the outputs are as follows: `mem_valid`, `per_ack`, `tc_pulse`, `tc_flag` and `cur_target` are all 0, and `remaining` is 0.
- R2: While enabled and waiting, a high `per_req` causes `per_data` to be captured. The captured data is presented on `mem_wdata` with `mem_valid` high in the next cycle. `per_ack` pulses high for exactly one cycle, in the cycle after the edge where `mem_valid` and `mem_ready` are both high.
- R3: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values, and no acknowledge is given.
- R4: The write address of the k-th item (k from 0) in a buffer is the active base plus k times `ITEM_BYTES`. Base 0 is used when `cur_target` is 0, and base 1 when it is 1.
- R5: On the last item of a buffer, `tc_pulse` is high in the same cycle as `per_ack`. In that same cycle `cur_target` has flipped and `remaining` has reloaded to `cfg_count`. The next item is written to the other base, at offset 0.
- R6: The channel carries on from buffer to buffer for as long as it is enabled, with no reprogramming and no re-enable.
- R7: `tc_flag` is set by every completion pulse and stays set. A cycle with `clr_we` high and `clr_mask` 1 clears it, while `clr_mask` 0 has no effect. If a clear and a completion land in the same cycle, the flag ends set.
- R8: With `cfg_en` low, requests start no write. A write already issued when the enable drops still completes and is acknowledged, and after that `mem_valid` stays low.
- R9: Raising `cfg_en` again restarts the channel with `cur_target` 0 and `remaining` equal to `cfg_count`.
- R10: With `cfg_count` equal to 0, the channel stays idle and starts no write, even while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_base0 | input | ADDR_W | Base address of buffer 0 |
| cfg_base1 | input | ADDR_W | Base address of buffer 1 |
| cfg_count | input | CNT_W | Items per buffer |
| clr_we | input | 1 | Strobe for a write to the interrupt-clear register |
| clr_mask | input | 1 | Clear mask; 1 clears the completion flag |
| per_req | input | 1 | Peripheral request |
| per_data | input | DATA_W | Peripheral data item |
| per_ack | output | 1 | One-cycle acknowledge to the peripheral |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| cur_target | output | 1 | Buffer currently being filled |
| remaining | output | CNT_W | Items left in the active buffer |
| tc_pulse | output | 1 | Buffer-complete pulse |
| tc_flag | output | 1 | Sticky buffer-complete flag |

## Verification
The assertions assume a peripheral that keeps `per_req` asserted until it sees `per_ack`, and then drops it before asking again. They also assume that `cfg_count`, the bases and the enable change only while the channel is idle, except for the enable drop that R8 tests on purpose. The stimulus keeps to these rules: it drops the request in the acknowledge cycle, and it changes the configuration only between scenarios with the enable low. Memory backpressure is produced by holding `mem_ready` low for a few cycles, which exercises the hold behaviour the assertions guard.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_WAIT  = 2'd1,
      CH_WRITE = 2'd2,
      CH_ACK   = 2'd3
   } ch_state_t;
endpackage

// File: rtl/dbuf_ptr_unit.sv
module dbuf_ptr_unit #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int ITEM_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic [CNT_W-1:0]  reload_val,
   output logic              tgt,
   output logic [CNT_W-1:0]  rem,
   output logic [ADDR_W-1:0] offset,
   output logic              tc
);
   localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(ITEM_BYTES);
   localparam logic [CNT_W-1:0]  ONE        = CNT_W'(1);

   if (ITEM_BYTES < 1) begin : g_bad_item
      $error("ITEM_BYTES must be at least 1");
   end

   assign tc = step && (rem == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt    <= 1'b0;
         rem    <= '0;
         offset <= '0;
      end else if (start) begin
         tgt    <= 1'b0;
         rem    <= reload_val;
         offset <= '0;
      end else if (tc) begin
         tgt    <= ~tgt;
         rem    <= reload_val;
         offset <= '0;
      end else if (step) begin
         rem    <= rem - ONE;
         offset <= offset + STEP_BYTES;
      end
   end

   // R5
   tgt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> (tgt != $past(tgt)) && (offset == '0));
   // R4
   offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !tc && !start) |=> offset == $past(offset) + STEP_BYTES);
endmodule

// File: rtl/dbuf_tc_flag.sv
module dbuf_tc_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag
);
   logic nxt;

   if (SET_WINS) begin : g_set_pri
      assign nxt = set_i | (flag & ~clr_i);
   end else begin : g_clr_pri
      assign nxt = ~clr_i & (set_i | flag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= nxt;
   end

   // R7
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && SET_WINS) |=> flag);
   // R7
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag);
endmodule

// File: rtl/dbuf_xfer_ctl.sv
module dbuf_xfer_ctl
   import dbuf_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cnt_ok,
   input  logic              per_req,
   input  logic [DATA_W-1:0] per_data,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              per_ack,
   output logic              start,
   output logic              step
);
   ch_state_t st, st_nxt;

   assign start = (st == CH_IDLE) && en && cnt_ok;
   assign step  = (st == CH_WRITE) && mem_ready;

   always_comb begin
      st_nxt = st;
      unique case (st)
         CH_IDLE:  if (start) st_nxt = CH_WAIT;
         CH_WAIT:  if (!en) st_nxt = CH_IDLE;
                   else if (per_req) st_nxt = CH_WRITE;
         CH_WRITE: if (mem_ready) st_nxt = CH_ACK;
         CH_ACK:   st_nxt = en ? CH_WAIT : CH_IDLE;
         default:  st_nxt = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= CH_IDLE;
         mem_addr  <= '0;
         mem_wdata <= '0;
         per_ack   <= 1'b0;
      end else begin
         st      <= st_nxt;
         per_ack <= step;
         if (st == CH_WAIT && en && per_req) begin
            mem_addr  <= next_addr;
            mem_wdata <= per_data;
         end
      end
   end

   assign mem_valid = (st == CH_WRITE);

   // R3
   hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));
   // R2
   ack_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> per_ack);
   // R2
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_ack |=> !per_ack);
   // R8
   no_write_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !mem_valid) |=> !mem_valid);
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int ITEM_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [ADDR_W-1:0] cfg_base0,
   input  logic [ADDR_W-1:0] cfg_base1,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              clr_we,
   input  logic              clr_mask,
   input  logic              per_req,
   input  logic [DATA_W-1:0] per_data,
   output logic              per_ack,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              cur_target,
   output logic [CNT_W-1:0]  remaining,
   output logic              tc_pulse,
   output logic              tc_flag
);
   if (ADDR_W < 2 || DATA_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("dbuf_dma_chan: widths out of range");
   end

   logic              start, step;
   logic [ADDR_W-1:0] offset, next_addr;

   assign next_addr = (cur_target ? cfg_base1 : cfg_base0) + offset;

   dbuf_xfer_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .en(cfg_en), .cnt_ok(cfg_count != '0),
      .per_req(per_req), .per_data(per_data), .next_addr(next_addr),
      .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .per_ack(per_ack), .start(start), .step(step)
   );

   logic tc_now;

   dbuf_ptr_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ITEM_BYTES(ITEM_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .reload_val(cfg_count), .tgt(cur_target), .rem(remaining),
      .offset(offset), .tc(tc_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tc_pulse <= 1'b0;
      else        tc_pulse <= tc_now;
   end

   dbuf_tc_flag #(.SET_WINS(1'b1)) u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(tc_now), .clr_i(clr_we && clr_mask),
      .flag(tc_flag)
   );

   // R5
   tc_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> per_ack);
   // R10
   zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_count == '0 && !mem_valid && !per_ack) |=> !mem_valid);
endmodule

// File: tb/sim_dbuf_dma_chan.sv
module sim_dbuf_dma_chan;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32, DW = 32, CW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_en = 1'b0;
   logic [AW-1:0] cfg_base0 = 32'h1000, cfg_base1 = 32'h2000;
   logic [CW-1:0] cfg_count = 16'd3;
   logic clr_we = 1'b0, clr_mask = 1'b0;
   logic per_req = 1'b0;
   logic [DW-1:0] per_data = '0;
   logic per_ack, mem_valid, mem_ready, cur_target, tc_pulse, tc_flag;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [CW-1:0] remaining;
   int checks = 0, fails = 0;

   assign mem_ready = rdy;
   logic rdy = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbuf_dma_chan u0 (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base0(cfg_base0),
      .cfg_base1(cfg_base1), .cfg_count(cfg_count), .clr_we(clr_we),
      .clr_mask(clr_mask), .per_req(per_req), .per_data(per_data),
      .per_ack(per_ack), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_target(cur_target),
      .remaining(remaining), .tc_pulse(tc_pulse), .tc_flag(tc_flag)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_item(input logic [31:0] data, input logic [31:0] exp_addr,
                          input logic exp_tc, input logic exp_tgt,
                          input logic clr_at_accept);
      logic [31:0] ga = '0, gd = '0;
      logic got_ack = 1'b0;
      per_data = data;
      per_req  = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (per_ack) begin got_ack = 1'b1; break; end
         if (mem_valid && mem_ready) begin
            ga = mem_addr; gd = mem_wdata;
            if (clr_at_accept) begin clr_we = 1'b1; clr_mask = 1'b1; end
         end
      end
      clr_we = 1'b0; clr_mask = 1'b0;
      chk("R2 ack seen", got_ack, 1'b1);
      chk("R4 address", ga, exp_addr);
      chk("R2 data", gd, data);
      chk("R5 tc_pulse", tc_pulse, exp_tc);
      chk("R5 cur_target", cur_target, exp_tgt);
      if (exp_tc) chk("R5 reload", remaining, cfg_count);
      per_req = 1'b0;
      @(negedge clk);
      chk("R2 ack one cycle", per_ack, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 mem_valid", mem_valid, 1'b0);
      chk("R1 per_ack", per_ack, 1'b0);
      chk("R1 tc_flag", tc_flag, 1'b0);
      chk("R1 cur_target", cur_target, 1'b0);
      chk("R1 remaining", remaining, 0);
   endtask

   task automatic t_pingpong();
      cfg_count = 16'd3; cfg_en = 1'b1;
      @(negedge clk);
      chk("R9 start count", remaining, 3);
      do_item(32'hA0, 32'h1000, 1'b0, 1'b0, 1'b0);
      do_item(32'hA1, 32'h1004, 1'b0, 1'b0, 1'b0);
      do_item(32'hA2, 32'h1008, 1'b1, 1'b1, 1'b0);
      chk("R7 flag set", tc_flag, 1'b1);
      // R6 second buffer and wrap back with no re-enable
      do_item(32'hB0, 32'h2000, 1'b0, 1'b1, 1'b0);
      do_item(32'hB1, 32'h2004, 1'b0, 1'b1, 1'b0);
      do_item(32'hB2, 32'h2008, 1'b1, 1'b0, 1'b0);
      do_item(32'hC0, 32'h1000, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_flag_clear();
      clr_we = 1'b1; clr_mask = 1'b0;
      @(negedge clk);
      clr_we = 1'b0;
      chk("R7 mask zero ignored", tc_flag, 1'b1);
      clr_we = 1'b1; clr_mask = 1'b1;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = 1'b0;
      chk("R7 cleared", tc_flag, 1'b0);
      do_item(32'hC1, 32'h1004, 1'b0, 1'b0, 1'b0);
      do_item(32'hC2, 32'h1008, 1'b1, 1'b1, 1'b1);
      chk("R7 set wins", tc_flag, 1'b1);
   endtask

   task automatic t_backpressure();
      logic [31:0] a0;
      rdy = 1'b0; per_data = 32'hD0; per_req = 1'b1;
      @(negedge clk); @(negedge clk);
      a0 = mem_addr;
      chk("R3 valid", mem_valid, 1'b1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R3 held", {mem_valid, per_ack}, 2'b10);
         chk("R3 addr stable", mem_addr, a0);
      end
      chk("R4 addr", a0, 32'h2000);
      rdy = 1'b1;
      @(negedge clk);
      chk("R2 ack after accept", per_ack, 1'b1);
      per_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_disable_restart();
      logic seen = 1'b0;
      cfg_en = 1'b0; per_req = 1'b1; per_data = 32'hE0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (mem_valid) seen = 1'b1;
      end
      chk("R8 no write when disabled", seen, 1'b0);
      per_req = 1'b0; cfg_count = 16'd4; cfg_en = 1'b1;
      @(negedge clk);
      chk("R9 restart target", cur_target, 1'b0);
      chk("R9 restart count", remaining, 4);
      do_item(32'hE1, 32'h1000, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_disable_inflight();
      logic seen = 1'b0, acked = 1'b0;
      rdy = 1'b0; per_req = 1'b1; per_data = 32'hF0;
      @(negedge clk); @(negedge clk);
      chk("R8 in flight", mem_valid, 1'b1);
      cfg_en = 1'b0; rdy = 1'b1;
      @(negedge clk);
      chk("R8 completes", per_ack, 1'b1);
      chk("R8 data", mem_wdata, 32'hF0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (mem_valid) seen = 1'b1;
         if (per_ack) acked = 1'b1;
      end
      chk("R8 stopped", {seen, acked}, 2'b00);
      per_req = 1'b0;
   endtask

   task automatic t_count_one_and_zero();
      logic seen = 1'b0;
      cfg_count = 16'd1; cfg_en = 1'b1;
      @(negedge clk);
      do_item(32'h11, 32'h1000, 1'b1, 1'b1, 1'b0);
      do_item(32'h12, 32'h2000, 1'b1, 1'b0, 1'b0);
      cfg_en = 1'b0;
      @(negedge clk);
      cfg_count = 16'd0; cfg_en = 1'b1; per_req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (mem_valid) seen = 1'b1;
      end
      chk("R10 zero count idle", seen, 1'b0);
      per_req = 1'b0; cfg_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pingpong();
      t_flag_clear();
      t_backpressure();
      t_disable_restart();
      t_disable_inflight();
      t_count_one_and_zero();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule